// File: doc/BRIEF.md
# NAND Sector ECC Checker and Corrector

This block judges a 512-byte NAND sector by comparing two 3-byte row/column parity codes. One is the code read back from the spare area of the flash. The other is the code recomputed over the data just read. From the XOR of the two codes it sorts the sector into one of four classes:

- clean;
- one flipped data bit that can be repaired;
- a flipped bit inside the stored code alone;
- damage beyond repair.

For the repairable class it also reports which byte of the sector and which bit of that byte must be inverted.

A host pulses `start_i` with both codes and the blank-page option on the inputs. The verdict is registered and appears one clock later, together with a one-cycle `done_o` pulse. The verdict then stays on the outputs until the next start. When the blank-page option is set, a stored code of all ones means a page that was never programmed, and the block reports it as clean.

Code byte k occupies bits [8k+7:8k] of both code inputs. Difference byte dk is the XOR of stored and recomputed byte k.

Top module: `ecc_sector_corrector`

## Requirements
- R1: When the stored and recomputed codes are equal, the status is 0 (clean).
- R2: When `ignore_blank_i` is 1 and the stored code is 24'hFFFFFF, the status is 0 whatever the recomputed code is. When `ignore_blank_i` is 0, such a code is classified by the normal rules.
- R3: When every difference byte d satisfies ((d ^ (d >> 1)) & 8'h55) == 8'h55, the status is 1 (data bit corrected).
- R4: With status 1, `byte_idx_o` is {d2[1], d1[7], d1[5], d1[3], d1[1], d0[7], d0[5], d0[3], d0[1]}, with the most significant bit first.
- R5: With status 1, `bit_idx_o` is {d2[7], d2[5], d2[3]}, with the most significant bit first.
- R6: When the 24-bit difference has exactly one bit set, and R2 does not apply, the status is 2 (error in the stored code only).
- R7: Every other non-zero difference, where R2 does not apply, gives status 3 (uncorrectable).
- R8: Whenever the status is not 1, `byte_idx_o` and `bit_idx_o` are zero.
- R9: `done_o` is high for exactly the one clock that follows a clock with `start_i` high. Status and indices change only on a start and hold their values otherwise. Starts in consecutive clocks each produce a result.
- R10: After reset, `done_o` is 0, the status is 0 and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Evaluate the presented codes in this cycle |
| stored_ecc_i | input | 24 | Code read from the flash spare area, byte k at [8k+7:8k] |
| calc_ecc_i | input | 24 | Code recomputed over the sector data, same byte layout |
| ignore_blank_i | input | 1 | Treat an all-ones stored code as an unprogrammed page |
| done_o | output | 1 | One-cycle pulse marking a new result |
| status_o | output | 2 | 0 clean, 1 data bit corrected, 2 code-only error, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte of the sector to repair (status 1 only) |
| bit_idx_o | output | 3 | Bit within that byte to invert (status 1 only) |

## Verification
The blank-page override and the parity classification act in the same cycle on the same start. A stored code of all ones can produce a difference that, taken alone, looks repairable, shows a single bit, or looks beyond repair. The bench presents all-ones stored codes against recomputed codes built to fall into each of those classes, once with the option set and once with it clear. It expects the clean status only when the option is set. It also issues starts in back-to-back cycles and checks that the second verdict replaces the first without a gap in `done_o`.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int ECC_BYTES   = 3;
  localparam int DIFF_W      = 8 * ECC_BYTES;
  localparam int BYTE_IDX_W  = 9;
  localparam int BIT_IDX_W   = 3;
  localparam int STATUS_W    = 2;

  typedef enum logic [STATUS_W-1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_ECC_ONLY = 2'd2,
    ST_FATAL    = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/ecc_diff_unit.sv
module ecc_diff_unit
  import ecc_chk_pkg::*;
(
  input  logic [DIFF_W-1:0] stored_ecc,
  input  logic [DIFF_W-1:0] calc_ecc,
  input  logic              ignore_blank,
  output logic [DIFF_W-1:0] diff,
  output logic              diff_zero,
  output logic              blank_skip
);
  // Difference between the two codes, one bit per parity term.
  assign diff       = stored_ecc ^ calc_ecc;
  assign diff_zero  = (diff == '0);
  // An erased page reads back as all ones in the spare area.
  assign blank_skip = ignore_blank && (&stored_ecc);
endmodule

// File: rtl/ecc_class_unit.sv
module ecc_class_unit
  import ecc_chk_pkg::*;
(
  input  logic [DIFF_W-1:0] diff,
  input  logic              diff_zero,
  input  logic              blank_skip,
  output ecc_status_e       status
);
  logic [ECC_BYTES-1:0] pair_ok;
  logic                 all_pairs_ok;
  logic                 one_hot_diff;
  logic [DIFF_W-1:0]    diff_minus1;

  // A single data-bit flip inverts exactly one member of every
  // parity pair, so each pair in each byte must differ.
  generate
    for (genvar g = 0; g < ECC_BYTES; g++) begin : g_pair
      logic [7:0] dbyte;
      logic [7:0] neigh;
      assign dbyte      = diff[8*g +: 8];
      assign neigh      = dbyte ^ (dbyte >> 1);
      assign pair_ok[g] = ((neigh & 8'h55) == 8'h55);
    end
  endgenerate

  assign all_pairs_ok = &pair_ok;
  assign diff_minus1  = diff - 1'b1;
  assign one_hot_diff = !diff_zero && ((diff & diff_minus1) == '0);

  always_comb begin
    if (diff_zero || blank_skip) status = ST_CLEAN;
    else if (all_pairs_ok)       status = ST_DATA_FIX;
    else if (one_hot_diff)       status = ST_ECC_ONLY;
    else                         status = ST_FATAL;
  end
endmodule

// File: rtl/ecc_locate_unit.sv
module ecc_locate_unit
  import ecc_chk_pkg::*;
(
  input  logic [DIFF_W-1:0]     diff,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx
);
  // The odd-numbered difference bits carry the location: the lower
  // nine of them give the byte, the upper three give the bit.
  localparam int ODD_W = DIFF_W / 2;

  logic [ODD_W-1:0] odd_bits;

  generate
    for (genvar j = 0; j < ODD_W; j++) begin : g_odd
      assign odd_bits[j] = diff[2*j + 1];
    end
  endgenerate

  assign byte_idx = odd_bits[BYTE_IDX_W-1:0];
  assign bit_idx  = odd_bits[BYTE_IDX_W +: BIT_IDX_W];
endmodule

// File: rtl/ecc_sector_corrector.sv
module ecc_sector_corrector
  import ecc_chk_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [DIFF_W-1:0]     stored_ecc_i,
  input  logic [DIFF_W-1:0]     calc_ecc_i,
  input  logic                  ignore_blank_i,
  output logic                  done_o,
  output logic [STATUS_W-1:0]   status_o,
  output logic [BYTE_IDX_W-1:0] byte_idx_o,
  output logic [BIT_IDX_W-1:0]  bit_idx_o
);
  logic                  srst_n;
  logic [DIFF_W-1:0]     diff;
  logic                  diff_zero;
  logic                  blank_skip;
  ecc_status_e           cls_status;
  logic [BYTE_IDX_W-1:0] loc_byte;
  logic [BIT_IDX_W-1:0]  loc_bit;

  ecc_status_e           status_q, status_d;
  logic [BYTE_IDX_W-1:0] byte_q, byte_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;
  logic                  done_q, done_d;
  logic                  res_en;

  ecc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ecc_diff_unit u_diff (
    .stored_ecc   (stored_ecc_i),
    .calc_ecc     (calc_ecc_i),
    .ignore_blank (ignore_blank_i),
    .diff         (diff),
    .diff_zero    (diff_zero),
    .blank_skip   (blank_skip)
  );

  ecc_class_unit u_class (
    .diff       (diff),
    .diff_zero  (diff_zero),
    .blank_skip (blank_skip),
    .status     (cls_status)
  );

  ecc_locate_unit u_loc (
    .diff     (diff),
    .byte_idx (loc_byte),
    .bit_idx  (loc_bit)
  );

  // Next-state: results load on a start; indices load only for a
  // repairable data error and are cleared otherwise.
  always_comb begin
    res_en   = start_i;
    done_d   = start_i;
    status_d = status_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    if (res_en) begin
      status_d = cls_status;
      if (cls_status == ST_DATA_FIX) begin
        byte_d = loc_byte;
        bit_d  = loc_bit;
      end else begin
        byte_d = '0;
        bit_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q   <= 1'b0;
      status_q <= ST_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      done_q <= done_d;
      if (res_en) begin
        status_q <= status_d;
        byte_q   <= byte_d;
        bit_q    <= bit_d;
      end
    end
  end

  assign done_o     = done_q;
  assign status_o   = status_q;
  assign byte_idx_o = byte_q;
  assign bit_idx_o  = bit_q;
endmodule

// File: rtl/ecc_sector_corrector_chk.sv
module ecc_sector_corrector_chk
  import ecc_chk_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic [DIFF_W-1:0]     stored_ecc_i,
  input logic [DIFF_W-1:0]     calc_ecc_i,
  input logic                  ignore_blank_i,
  input logic                  done_o,
  input logic [STATUS_W-1:0]   status_o,
  input logic [BYTE_IDX_W-1:0] byte_idx_o,
  input logic [BIT_IDX_W-1:0]  bit_idx_o
);
  logic blank_case;
  assign blank_case = ignore_blank_i && (stored_ecc_i == {DIFF_W{1'b1}});

  assert_clean_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stored_ecc_i == calc_ecc_i) |=> (status_o == 2'd0));

  assert_blank_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && blank_case) |=> (status_o == 2'd0));

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !blank_case && $countones(stored_ecc_i ^ calc_ecc_i) == 1)
      |=> (status_o == 2'd2));

  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'd1) |-> (byte_idx_o == '0 && bit_idx_o == '0));

  assert_done_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  assert_done_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));
endmodule

bind ecc_sector_corrector ecc_sector_corrector_chk u_chk (
  .clk            (clk),
  .rst_n          (srst_n),
  .start_i        (start_i),
  .stored_ecc_i   (stored_ecc_i),
  .calc_ecc_i     (calc_ecc_i),
  .ignore_blank_i (ignore_blank_i),
  .done_o         (done_o),
  .status_o       (status_o),
  .byte_idx_o     (byte_idx_o),
  .bit_idx_o      (bit_idx_o)
);

// File: tb/ecc_sector_corrector_tb.sv
module ecc_sector_corrector_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] stored_ecc_i;
  logic [23:0] calc_ecc_i;
  logic        ignore_blank_i;
  logic        done_o;
  logic [1:0]  status_o;
  logic [8:0]  byte_idx_o;
  logic [2:0]  bit_idx_o;

  int checks   = 0;
  int failures = 0;

  ecc_sector_corrector u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stored_ecc_i   (stored_ecc_i),
    .calc_ecc_i     (calc_ecc_i),
    .ignore_blank_i (ignore_blank_i),
    .done_o         (done_o),
    .status_o       (status_o),
    .byte_idx_o     (byte_idx_o),
    .bit_idx_o      (bit_idx_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected {status, byte, bit}, worked out from the requirements.
  function automatic logic [13:0] expect_of(input logic [23:0] st,
                                            input logic [23:0] ca,
                                            input logic ign);
    logic [23:0] d;
    logic        ok;
    int          ones;
    d = st ^ ca;
    if (d == 24'h0 || (ign && st == 24'hFFFFFF)) return 14'h0;
    ok = 1'b1;
    for (int i = 0; i < 12; i++) if (d[2*i+1] == d[2*i]) ok = 1'b0;
    if (ok)
      return {2'd1, d[17], d[15], d[13], d[11], d[9], d[7], d[5], d[3], d[1],
              d[23], d[21], d[19]};
    ones = 0;
    for (int i = 0; i < 24; i++) ones += int'(d[i]);
    if (ones == 1) return {2'd2, 12'h0};
    return {2'd3, 12'h0};
  endfunction

  // Difference pattern of a repairable flip at byte b, bit k.
  function automatic logic [23:0] fix_pattern(input logic [8:0] b,
                                              input logic [2:0] k);
    logic [11:0] o;
    logic [23:0] d;
    o = {k, b};
    for (int j = 0; j < 12; j++) begin
      d[2*j+1] = o[j];
      d[2*j]   = ~o[j];
    end
    return d;
  endfunction

  function automatic string req_for(input logic [1:0] s, input logic [23:0] st,
                                    input logic ign);
    if (ign && st == 24'hFFFFFF) return "R2";
    case (s)
      2'd0: return "R1";
      2'd1: return "R3/R4/R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [13:0] last_exp;

  // Present a start at the current negedge; check the verdict one clock later.
  task automatic issue(input logic [23:0] st, input logic [23:0] ca,
                       input logic ign);
    logic [13:0] e;
    string       r;
    start_i        = 1'b1;
    stored_ecc_i   = st;
    calc_ecc_i     = ca;
    ignore_blank_i = ign;
    e = expect_of(st, ca, ign);
    r = req_for(e[13:12], st, ign);
    @(negedge clk);
    check("R9", "done after start", {31'h0, done_o}, 32'h1);
    check(r, "status", {30'h0, status_o}, {30'h0, e[13:12]});
    check((e[13:12] == 2'd1) ? "R4" : "R8", "byte index", {23'h0, byte_idx_o}, {23'h0, e[11:3]});
    check((e[13:12] == 2'd1) ? "R5" : "R8", "bit index", {29'h0, bit_idx_o}, {29'h0, e[2:0]});
    last_exp = e;
  endtask

  // One clock without a start and with scrambled inputs: result must hold.
  task automatic idle();
    start_i        = 1'b0;
    stored_ecc_i   = 24'($urandom);
    calc_ecc_i     = 24'($urandom);
    ignore_blank_i = 1'($urandom);
    @(negedge clk);
    check("R9", "done is a single pulse", {31'h0, done_o}, 32'h0);
    check("R9", "held result", {18'h0, status_o, byte_idx_o, bit_idx_o},
          {18'h0, last_exp});
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n          = 1'b0;
    start_i        = 1'b0;
    stored_ecc_i   = 24'h0;
    calc_ecc_i     = 24'h0;
    ignore_blank_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "reset done", {31'h0, done_o}, 32'h0);
    check("R10", "reset result", {18'h0, status_o, byte_idx_o, bit_idx_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "result after release", {18'h0, status_o, byte_idx_o, bit_idx_o}, 32'h0);
    last_exp = 14'h0;

    // R1: equal codes.
    issue(24'h5A3C96, 24'h5A3C96, 1'b0); idle();
    // R3/R4/R5: extreme locations.
    issue(24'h123456, 24'h123456 ^ fix_pattern(9'd0, 3'd0), 1'b0); idle();
    issue(24'h000000, fix_pattern(9'd511, 3'd7), 1'b0); idle();
    issue(24'hABCDEF, 24'hABCDEF ^ fix_pattern(9'h155, 3'd5), 1'b0); idle();
    // R6: one bit at each end of the code.
    issue(24'h000000, 24'h000001, 1'b0); idle();
    issue(24'h7FFFFF, 24'hFFFFFF, 1'b0); idle();
    // R7: two bits, and all bits.
    issue(24'h000000, 24'h000003, 1'b0); idle();
    issue(24'hFFFFFF, 24'h000000, 1'b0); idle();
    // R2: blank override against every class, with the option on and off.
    issue(24'hFFFFFF, 24'hFFFFFF ^ fix_pattern(9'd77, 3'd2), 1'b1); idle();
    issue(24'hFFFFFF, 24'hFFFFFF ^ fix_pattern(9'd77, 3'd2), 1'b0); idle();
    issue(24'hFFFFFF, 24'hFFFFFE, 1'b1); idle();
    issue(24'hFFFFFF, 24'hFFFFFE, 1'b0); idle();
    issue(24'hFFFFFF, 24'h123456, 1'b1); idle();
    issue(24'hFFFFFF, 24'h123456, 1'b0); idle();
    // R9: back-to-back starts with differing verdicts.
    issue(24'h000000, fix_pattern(9'd300, 3'd4), 1'b0);
    issue(24'h000000, 24'h000010, 1'b0);
    issue(24'h000000, 24'h00F00F, 1'b0);
    issue(24'h654321, 24'h654321, 1'b1);
    idle();

    // Constrained random mix.
    for (int n = 0; n < 400; n++) begin
      logic [23:0] st;
      logic [23:0] ca;
      logic        ign;
      int          kind;
      kind = int'($urandom % 6);
      ign  = 1'($urandom);
      st   = ($urandom % 8 == 0) ? 24'hFFFFFF : 24'($urandom);
      case (kind)
        0: ca = st;
        1, 2: ca = st ^ fix_pattern(9'($urandom), 3'($urandom));
        3: ca = st ^ (24'h1 << ($urandom % 24));
        default: ca = 24'($urandom);
      endcase
      issue(st, ca, ign);
      if ($urandom % 3 != 0) idle();
    end
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule